// File: doc/BRIEF.md
# Pipelined Programmable Clock Divider

The block divides its input clock by a programmable integer N from 1 to 256. It emits a pulse one input-clock cycle wide once every N cycles. The divide ratio comes in on an 8-bit word that carries N-1. Internally a down counter holds the cycles left in the current period. The counter is split into identical 2-bit digits, and every flop runs on the same clock edge. No digit looks at a full-width borrow chain in the same cycle. Instead, each digit's decrement enable is computed one cycle early and held in a register.

Terminal count is found in two levels. Each digit is decoded on its own, and then the per-digit flags are combined. The decoder looks for a count of one rather than zero, so the single reload register fires exactly in the last cycle of the period. That reload register is also the output. When it is high, the counter loads the ratio word on the next edge. The ratio word is read only at that moment, so a new value never cuts the current period short. A ratio word of zero (N=1) keeps the reload register, and so the output, high on every cycle.

Top module: `clkdiv_lookahead`

## Requirements
- R1: With ratio word R, successive rising edges of `div_pulse` are exactly R+1 input-clock cycles apart. The ratio word holds N-1, so 0x00 means N=1 and 0xFF means N=256.
- R2: With ratio word 0, `div_pulse` is high on every cycle, including the first cycle after a reset edge.
- R3: For R of 1 or more, `div_pulse` is high for exactly one cycle per period.
- R4: `ratio` is read only in the cycle where `div_pulse` is high (and during reset). A change made in the middle of a period takes effect only for the period that follows the next pulse.
- R5: `rst` is synchronous and active high. While it is sampled high with R of 1 or more, `div_pulse` is low. After release, the first pulse appears after the R-th rising edge at which `rst` is low.
- R6: Every 2-bit digit decrements exactly when all lower digits are zero. This decision comes from a registered look-ahead enable, so periods that borrow across digit boundaries (N = 17, 256 and so on) keep their exact length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | 8 | Divide ratio minus one (N-1) |
| div_pulse | output | 1 | One-cycle pulse once per N cycles |

## Verification
The embedded assertions check the following on every cycle:
- The count steps down by exactly one outside a reload.
- The counter loads the ratio value sampled on the reload cycle.
- Each registered look-ahead enable equals the zero state of the digits below it.
- The reload register fires exactly when a cycle counter kept beside the design runs out.

Other behaviours appear only at the ports, so the bench's scenarios must show them:
- The period lengths across a sweep of N, including the digit-boundary values 16, 17, 255 and 256.
- The delayed effect of a ratio change made mid-period.
- The first-pulse latency after reset.

// File: rtl/clkdiv_lookahead.sv
module clkdiv_lookahead #(
  parameter int STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*STAGES-1:0]   ratio,
  output logic                  div_pulse
);
  localparam int W = 2 * STAGES;

  logic [STAGES-1:0][1:0] dig;
  logic [STAGES-1:0]      en_q;
  logic                   reload_q;
  logic [STAGES-1:0]      zero_d;
  logic [STAGES:0]        la;
  logic [STAGES:0]        ld;
  logic [W-1:0]           cnt;

  assign cnt = dig;

  // first decoder level: per-digit flags
  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_dec
      assign zero_d[k] = (dig[k] == 2'd0);
    end
  endgenerate

  // second level: la[k] = lower k digits hold exactly one; ld[k] = lower k ratio digits are zero
  assign la[0] = 1'b1;
  assign ld[0] = 1'b1;
  generate
    for (k = 1; k <= STAGES; k++) begin : g_la
      if (k == 1) begin : g_first
        assign la[k] = (dig[0] == 2'd1);
      end else begin : g_rest
        assign la[k] = la[k-1] & zero_d[k-1];
      end
      assign ld[k] = ld[k-1] & (ratio[2*k-1 -: 2] == 2'd0);
    end
  endgenerate

  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || reload_q) begin
          dig[k]  <= ratio[2*k+1 -: 2];
          en_q[k] <= ld[k];
        end else begin
          if (en_q[k]) dig[k] <= dig[k] - 2'd1;
          en_q[k] <= la[k];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || reload_q) reload_q <= ld[STAGES];
    else                 reload_q <= la[STAGES];
  end

  assign div_pulse = reload_q;

  // period checker kept beside the counter
  logic         a_armed;
  logic [W-1:0] a_left;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_armed <= 1'b0;
      a_left  <= '0;
    end else if (reload_q) begin
      a_armed <= 1'b1;
      a_left  <= ratio;
    end else begin
      a_left  <= a_left - W'(1);
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (rst)
    a_armed |-> (reload_q == (a_left == '0)));

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (reload_q && ratio == '0) |=> reload_q);

  p_single_r3: assert property (@(posedge clk) disable iff (rst)
    (reload_q && ratio != '0) |=> !reload_q);

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    reload_q |=> (cnt == $past(ratio)));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !reload_q |=> (cnt == $past(cnt) - W'(1)));

  p_reload_zero_r6: assert property (@(posedge clk) disable iff (rst)
    reload_q |-> (cnt == '0));

  generate
    for (k = 1; k < STAGES; k++) begin : g_chk
      p_lookahead_r6: assert property (@(posedge clk) disable iff (rst)
        en_q[k] == (cnt[2*k-1:0] == '0));
    end
  endgenerate
endmodule

// File: tb/test_clkdiv_lookahead.sv
`timescale 1ns/1ps
module test_clkdiv_lookahead;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ratio = 8'd0;
  logic       div_pulse;
  int checks = 0;
  int fails  = 0;

  clkdiv_lookahead i_clkdiv_lookahead (
    .clk(clk), .rst(rst), .ratio(ratio), .div_pulse(div_pulse));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!div_pulse && n < 2000);
  endtask

  task automatic test_reset(input int r);
    int n;
    ratio = 8'(r);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check(div_pulse == 1'b0, "R5 low in reset", int'(div_pulse), 0);
    rst = 1'b0;
    wait_pulse(n);
    check(n == r, "R5 first pulse latency", n, r);
  endtask

  task automatic test_reset_bypass();
    rst = 1'b1;
    ratio = 8'd0;
    tick();
    tick();
    check(div_pulse == 1'b1, "R2 high in reset", int'(div_pulse), 1);
    rst = 1'b0;
    tick();
    check(div_pulse == 1'b1, "R2 high after reset", int'(div_pulse), 1);
  endtask

  task automatic test_period(input int r);
    int n;
    bit all_ok = 1'b1;
    ratio = 8'(r);
    wait_pulse(n);
    wait_pulse(n);
    if (r == 0) begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (div_pulse) hi++;
      end
      check(hi == 20, "R2 bypass every cycle", hi, 20);
    end else begin
      for (int p = 0; p < 3; p++) begin
        tick();
        check(div_pulse == 1'b0, "R3 one-cycle width", int'(div_pulse), 0);
        wait_pulse(n);
        n = n + 1;
        check(n == r + 1, "R1 period", n, r + 1);
        if (n != r + 1) all_ok = 1'b0;
      end
      if (r >= 4) check(all_ok, "R6 borrow across digits", int'(all_ok), 1);
    end
  endtask

  task automatic test_change(input int a, input int b);
    int n;
    ratio = 8'(a);
    wait_pulse(n);
    wait_pulse(n);
    tick();
    tick();
    ratio = 8'(b);
    wait_pulse(n);
    check(n + 2 == a + 1, "R4 old ratio holds", n + 2, a + 1);
    wait_pulse(n);
    check(n == b + 1, "R4 new ratio applies", n, b + 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset(5);
    test_reset(1);
    test_reset_bypass();
    test_period(0);
    test_period(1);
    test_period(2);
    test_period(3);
    test_period(4);
    test_period(15);
    test_period(16);
    test_period(254);
    test_period(255);
    test_change(6, 2);
    test_change(3, 200);
    test_change(10, 0);
    test_reset(17);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule